// File: doc/BRIEF.md
# Drive Head Position and Media-Change Tracker

This block keeps the state of one drive's head as the controller sees it. It tracks the cylinder under the head, and it runs three kinds of seek. An absolute seek moves the head to a target cylinder. A relative seek moves it toward the spindle by a step count, and another relative seek moves it toward the rim by a step count. Every seek finishes in the cycle after its request. The block then gives a one-cycle done pulse and holds a pending seek-end status. A sense-status read collects that status.

The block also keeps a media-change flag, which software reads as the top bit of the drive input register. Reading the flag never clears it. Only a real head movement clears it, and only while a medium is in the drive. Inserting a medium leaves the flag set. Ejecting the medium sets the flag again.

Top module: `drive_track_state`

## Requirements
- R1: After reset the cylinder is 0, the change flag is 1, seek_done is 0, the drive is empty and sense_st0 reads 8'h80 (no seek pending).
- R2: An absolute seek (seek_mode 2'b00, and 2'b11 behaves the same) sets the cylinder to seek_arg one cycle after the request. A seek_arg above MAX_CYL (79) is clamped to 79.
- R3: An inward relative seek (seek_mode 2'b01) adds seek_arg to the cylinder and saturates at MAX_CYL (79).
- R4: An outward relative seek (seek_mode 2'b10) subtracts seek_arg from the cylinder and saturates at 0.
- R5: seek_done is high for exactly the one cycle that follows each seek request, including a seek that does not move the head.
- R6: Once a seek completes, sense_st0 reads 8'h20 (seek-end bit 5) until a sense_rd strobe returns it to 8'h80. When sense_rd and seek_req arrive in the same cycle, sense_st0 reads 8'h20 afterwards.
- R7: A dir_rd strobe loads dir_q with the change flag in bit 7 and zeros in bits 6:0. Reading never changes the flag.
- R8: A seek that moves the head to a different cylinder while a medium is present clears the change flag. A seek to the cylinder the head is already on leaves the flag unchanged.
- R9: media_insert does not clear the change flag, and media_eject sets it. Seeks made while the drive is empty never clear it.
- R10: When an eject or an insert arrives in the same cycle as a seek that moves the head, the change flag ends up set. The head still moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seek_req | input | 1 | One-cycle seek request |
| seek_mode | input | 2 | 00/11 absolute, 01 inward relative, 10 outward relative |
| seek_arg | input | CW | Target cylinder or step count |
| media_insert | input | 1 | Medium inserted event |
| media_eject | input | 1 | Medium ejected event |
| dir_rd | input | 1 | Drive input register read strobe |
| sense_rd | input | 1 | Sense-status read strobe, collects a pending seek end |
| cyl | output | CW | Present cylinder |
| seek_done | output | 1 | One-cycle pulse after each seek |
| disk_chg | output | 1 | Media-change flag |
| dir_q | output | 8 | Drive input register value captured on dir_rd |
| sense_st0 | output | 8 | 8'h20 when a seek end is pending, else 8'h80 |

## Verification
Two functions can fall in the same cycle. A media event can arrive together with a seek that moves the head. A sense read can arrive together with a new seek request. The bench drives an eject with a stepping seek, and an insert with a stepping seek, in one cycle each. It expects the head to move and the change flag to end up set. It also drives sense_rd together with seek_req and expects the seek-end status to stay pending.

// File: rtl/drive_track_state.sv
module drive_track_state #(
  parameter int CW      = 8,
  parameter int MAX_CYL = 79
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seek_req,
  input  logic [1:0]    seek_mode,
  input  logic [CW-1:0] seek_arg,
  input  logic          media_insert,
  input  logic          media_eject,
  input  logic          dir_rd,
  input  logic          sense_rd,
  output logic [CW-1:0] cyl,
  output logic          seek_done,
  output logic          disk_chg,
  output logic [7:0]    dir_q,
  output logic [7:0]    sense_st0
);
  localparam logic [CW:0] MAXW = (CW+1)'(MAX_CYL);

  logic [CW-1:0] cyl_q, tgt;
  logic [CW:0]   sum;
  logic          chg_q, media_q, pend_q, done_q, step;

  assign sum = {1'b0, cyl_q} + {1'b0, seek_arg};

  always_comb begin
    case (seek_mode)
      2'b01:   tgt = (sum > MAXW) ? CW'(MAX_CYL) : sum[CW-1:0];
      2'b10:   tgt = (cyl_q > seek_arg) ? cyl_q - seek_arg : '0;
      default: tgt = ({1'b0, seek_arg} > MAXW) ? CW'(MAX_CYL) : seek_arg;
    endcase
  end

  assign step = seek_req && (tgt != cyl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyl_q   <= '0;
      chg_q   <= 1'b1;
      media_q <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      dir_q   <= 8'h00;
    end else begin
      done_q <= seek_req;
      if (seek_req) cyl_q <= tgt;
      if (seek_req) pend_q <= 1'b1;
      else if (sense_rd) pend_q <= 1'b0;
      if (media_eject) media_q <= 1'b0;
      else if (media_insert) media_q <= 1'b1;
      if (media_eject || media_insert) chg_q <= 1'b1;
      else if (step && media_q) chg_q <= 1'b0;
      if (dir_rd) dir_q <= {chg_q, 7'b0};
    end
  end

  assign cyl       = cyl_q;
  assign seek_done = done_q;
  assign disk_chg  = chg_q;
  assign sense_st0 = pend_q ? 8'h20 : 8'h80;

  // R5
  done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seek_req |=> seek_done);
  // R5
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seek_req |=> !seek_done);
  // R3
  cyl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyl <= CW'(MAX_CYL));
  // R9
  eject_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    media_eject |=> disk_chg);
  // R8
  clear_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disk_chg) |-> ($past(media_q) && cyl != $past(cyl)));
  // R7
  read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && !seek_req && disk_chg) |=> disk_chg);
  // R6
  pending_after_seek_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seek_req |=> sense_st0 == 8'h20);
endmodule

// File: tb/tb_drive_track_state.sv
module tb_drive_track_state;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seek_req = 1'b0, media_insert = 1'b0, media_eject = 1'b0;
  logic       dir_rd = 1'b0, sense_rd = 1'b0;
  logic [1:0] seek_mode = 2'b00;
  logic [7:0] seek_arg = 8'd0;
  logic [7:0] cyl, dir_q, sense_st0;
  logic       seek_done, disk_chg;
  int errors = 0, checks = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  drive_track_state dut (
    .clk(clk), .rst_n(rst_n), .seek_req(seek_req), .seek_mode(seek_mode),
    .seek_arg(seek_arg), .media_insert(media_insert), .media_eject(media_eject),
    .dir_rd(dir_rd), .sense_rd(sense_rd), .cyl(cyl), .seek_done(seek_done),
    .disk_chg(disk_chg), .dir_q(dir_q), .sense_st0(sense_st0));

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_seek(logic [1:0] m, logic [7:0] a);
    @(negedge clk);
    seek_req = 1'b1; seek_mode = m; seek_arg = a;
    @(negedge clk);
    seek_req = 1'b0;
  endtask

  task automatic pulse_insert();
    @(negedge clk); media_insert = 1'b1;
    @(negedge clk); media_insert = 1'b0;
  endtask

  task automatic pulse_eject();
    @(negedge clk); media_eject = 1'b1;
    @(negedge clk); media_eject = 1'b0;
  endtask

  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 8'd10,  8'd10}, {2'b01, 8'd5,   8'd15}, {2'b10, 8'd3,  8'd12},
    {2'b10, 8'd50,  8'd0},  {2'b01, 8'd200, 8'd79}, {2'b01, 8'd1,  8'd79},
    {2'b00, 8'd100, 8'd79}, {2'b00, 8'd0,   8'd0},  {2'b10, 8'd1,  8'd0},
    {2'b00, 8'd79,  8'd79}};

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cyl", cyl, 8'd0);
    check("R1 chg", {7'b0, disk_chg}, 8'd1);
    check("R1 done", {7'b0, seek_done}, 8'd0);
    check("R1 sense", sense_st0, 8'h80);

    for (int k = 0; k < 2; k++) begin
      @(negedge clk); dir_rd = 1'b1;
      @(negedge clk); dir_rd = 1'b0;
      check("R7 dir read sticky", dir_q, 8'h80);
    end

    do_seek(2'b00, 8'd1);
    check("R5 done pulse", {7'b0, seek_done}, 8'd1);
    check("R9 empty seek keeps flag", {7'b0, disk_chg}, 8'd1);
    check("R6 seek end pending", sense_st0, 8'h20);
    @(negedge clk);
    check("R5 done one cycle", {7'b0, seek_done}, 8'd0);
    @(negedge clk); sense_rd = 1'b1;
    @(negedge clk); sense_rd = 1'b0;
    check("R6 sense collected", sense_st0, 8'h80);

    for (int i = 0; i < NV; i++) begin
      do_seek(VEC[i][17:16], VEC[i][15:8]);
      check(VEC[i][17:16] == 2'b01 ? "R3 inward" :
            VEC[i][17:16] == 2'b10 ? "R4 outward" : "R2 absolute",
            cyl, VEC[i][7:0]);
      check("R5 table done", {7'b0, seek_done}, 8'd1);
    end
    check("R9 flag after empty seeks", {7'b0, disk_chg}, 8'd1);

    pulse_insert();
    check("R9 insert keeps flag", {7'b0, disk_chg}, 8'd1);
    do_seek(2'b00, 8'd79);
    check("R8 same cylinder keeps flag", {7'b0, disk_chg}, 8'd1);
    check("R5 done without step", {7'b0, seek_done}, 8'd1);
    do_seek(2'b00, 8'd78);
    check("R8 step clears flag", {7'b0, disk_chg}, 8'd0);
    @(negedge clk); dir_rd = 1'b1;
    @(negedge clk); dir_rd = 1'b0;
    check("R7 dir shows clear", dir_q, 8'h00);

    pulse_eject();
    check("R9 eject sets flag", {7'b0, disk_chg}, 8'd1);
    do_seek(2'b00, 8'd5);
    check("R9 empty step keeps flag", {7'b0, disk_chg}, 8'd1);

    pulse_insert();
    do_seek(2'b00, 8'd6);
    check("R8 step after insert clears", {7'b0, disk_chg}, 8'd0);

    @(negedge clk);
    seek_req = 1'b1; seek_mode = 2'b00; seek_arg = 8'd20; media_eject = 1'b1;
    @(negedge clk);
    seek_req = 1'b0; media_eject = 1'b0;
    check("R10 eject with step flag", {7'b0, disk_chg}, 8'd1);
    check("R10 eject with step cyl", cyl, 8'd20);

    @(negedge clk);
    seek_req = 1'b1; seek_mode = 2'b01; seek_arg = 8'd2; media_insert = 1'b1;
    @(negedge clk);
    seek_req = 1'b0; media_insert = 1'b0;
    check("R10 insert with step flag", {7'b0, disk_chg}, 8'd1);
    check("R10 insert with step cyl", cyl, 8'd22);

    @(negedge clk); sense_rd = 1'b1;
    @(negedge clk); sense_rd = 1'b0;
    check("R6 cleared before race", sense_st0, 8'h80);
    @(negedge clk);
    seek_req = 1'b1; seek_mode = 2'b10; seek_arg = 8'd2; sense_rd = 1'b1;
    @(negedge clk);
    seek_req = 1'b0; sense_rd = 1'b0;
    check("R6 seek wins over sense", sense_st0, 8'h20);
    check("R4 outward after race", cyl, 8'd20);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule